// File: doc/BRIEF.md
# Rectifier Turn-Off Offset Accumulator

This block produces, once per switching cycle, a signed offset in timer ticks. The offset moves the turn-off edge of a synchronous rectifier PWM away from the nominal edge that the loop compensator computes. Its feedback input is the body-diode conduction count measured after the previous turn-off edge, which arrives with a one-cycle valid strobe. A long measured conduction means the switch was opened too early. A short one means it was opened too late. A conduction count that is almost zero signals a risk of reverse current through the rectifier.

In manual mode the block passes a programmed offset straight to its output. In automatic mode a signed accumulator moves one programmable step per strobe toward a target conduction time. No step is taken while the measurement is inside a hysteresis band around the target. Measurements below a fault threshold are counted. Once a programmed number of them occur in a row, one large reduction is subtracted. Every update of the accumulator is limited to a programmable minimum and maximum, which keeps the on-time from growing far enough to cause shoot-through. The accumulator restarts from zero whenever the block is disabled or is not in automatic mode.

Top module: `sr_ontime_adjust`

## Requirements
- R1: After reset is released, `ofs_out` is 0.
- R2: While `enable` is 0, `ofs_out` is 0 and strobes have no effect. The accumulator is cleared, so after `enable` returns to 1 it starts from 0.
- R3: While `enable` is 1 and `auto_mode` is 0, `ofs_out` equals `manual_ofs` and strobes have no effect. When the block enters automatic mode, the accumulator starts from 0.
- R4: In automatic mode, a strobe with `meas_cnt` greater than `target + hyst` raises the offset by `step`. The change is visible from the clock edge that samples the strobe.
- R5: In automatic mode, a strobe with `meas_cnt` at or above `flt_thresh` and below `target - hyst` (compared as signed, without wrap-around) lowers the offset by `step`.
- R6: A strobe with `meas_cnt` inside the band from `target - hyst` to `target + hyst`, both ends included, leaves the offset unchanged.
- R7: A strobe with `meas_cnt` below `flt_thresh` is a fault, and this check takes priority over R5. Faults are counted. The fault that brings the count up to `flt_limit` lowers the offset by `flt_step` and sets the count back to 0. Earlier faults in the run leave the offset unchanged. A `flt_limit` of 0 acts as 1.
- R8: A non-fault strobe sets the consecutive-fault count back to 0. The count is also cleared outside automatic mode.
- R9: Each accumulator update is clamped so that the result lies between `clamp_min` and `clamp_max`. This assumes `clamp_min` ≤ `clamp_max`.
- R10: The accumulator changes only on a clock edge where `meas_valid` is 1.
- R11: `ofs_out` is two's complement with `OFS_W` bits (12 by default), so negative offsets shorten the on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; 0 forces the output to zero and clears the state |
| auto_mode | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| meas_valid | input | 1 | Strobe, one cycle per switching period |
| meas_cnt | input | CNT_W | Measured conduction count |
| manual_ofs | input | OFS_W | Signed offset used in manual mode |
| target | input | CNT_W | Target conduction count |
| hyst | input | CNT_W | Half-width of the no-adjust band |
| step | input | STEP_W | Normal adjustment step |
| flt_thresh | input | CNT_W | Counts below this value are faults |
| flt_step | input | STEP_W | Reduction applied on a qualified fault |
| flt_limit | input | LIM_W | Number of consecutive faults needed to apply the reduction |
| clamp_min | input | OFS_W | Signed lower bound of the accumulator |
| clamp_max | input | OFS_W | Signed upper bound of the accumulator |
| ofs_out | output | OFS_W | Signed offset in timer ticks |

## Verification
Conduction counts are applied above the band, exactly on both band edges, just below the band, and exactly at the fault threshold. Together these separate lengthening, holding and shortening, and show that the band edges are inclusive and the fault threshold is exclusive. Runs of faults are applied with and without an interrupting in-band strobe. This separates a counter that qualifies correctly from one that fires at once or never resets. Large steps drive the accumulator against both clamps, and the enable, mode and strobe inputs are toggled to confirm that the state is cleared and held where required.

// File: rtl/sradj_pkg.sv
package sradj_pkg;
    typedef enum logic [1:0] {
        ADJ_HOLD  = 2'd0,
        ADJ_UP    = 2'd1,
        ADJ_DOWN  = 2'd2,
        ADJ_FAULT = 2'd3
    } adj_e;
endpackage

// File: rtl/sradj_classify.sv
module sradj_classify
    import sradj_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] meas,
    input  logic [CNT_W-1:0] target,
    input  logic [CNT_W-1:0] hyst,
    input  logic [CNT_W-1:0] flt_thresh,
    output adj_e             cls
);
    localparam int EXT_W = CNT_W + 2;

    logic signed [EXT_W-1:0] meas_s;
    logic signed [EXT_W-1:0] hi_s;
    logic signed [EXT_W-1:0] lo_s;

    always_comb begin
        meas_s = $signed({2'b00, meas});
        hi_s   = $signed({2'b00, target}) + $signed({2'b00, hyst});
        lo_s   = $signed({2'b00, target}) - $signed({2'b00, hyst});
        if (meas < flt_thresh) begin
            cls = ADJ_FAULT;
        end else if (meas_s > hi_s) begin
            cls = ADJ_UP;
        end else if (meas_s < lo_s) begin
            cls = ADJ_DOWN;
        end else begin
            cls = ADJ_HOLD;
        end
    end
endmodule

// File: rtl/sradj_fault_qual.sv
module sradj_fault_qual #(
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             is_fault,
    input  logic [LIM_W-1:0] limit,
    output logic             qualify
);
    typedef struct packed {
        logic [LIM_W-1:0] cnt;
    } fq_state_t;

    fq_state_t       st_d, st_q;
    logic [LIM_W-1:0] limit_eff;
    logic [LIM_W:0]   next_run;

    always_comb begin
        st_d      = st_q;
        qualify   = 1'b0;
        limit_eff = (limit == '0) ? LIM_W'(1) : limit;
        next_run  = {1'b0, st_q.cnt} + (LIM_W+1)'(1);
        if (clear) begin
            st_d.cnt = '0;
        end else if (sample) begin
            if (is_fault) begin
                if (next_run >= {1'b0, limit_eff}) begin
                    qualify  = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = next_run[LIM_W-1:0];
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a qualified fault restarts the run
    a_r7_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
        qualify |=> (st_q.cnt == '0));

    // R8: a clean strobe breaks the run
    a_r8_clean_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !is_fault) |=> (st_q.cnt == '0));
endmodule

// File: rtl/sradj_accum.sv
module sradj_accum
    import sradj_pkg::*;
#(
    parameter int OFS_W  = 12,
    parameter int STEP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    upd,
    input  adj_e                    adj,
    input  logic                    fault_go,
    input  logic [STEP_W-1:0]       step,
    input  logic [STEP_W-1:0]       flt_step,
    input  logic signed [OFS_W-1:0] clamp_min,
    input  logic signed [OFS_W-1:0] clamp_max,
    output logic signed [OFS_W-1:0] acc
);
    localparam int BASE_W = (OFS_W > STEP_W) ? OFS_W : STEP_W;
    localparam int SUM_W  = BASE_W + 2;

    typedef struct packed {
        logic signed [OFS_W-1:0] acc;
    } acc_state_t;

    acc_state_t              st_d, st_q;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] step_s;
    logic signed [SUM_W-1:0] fstep_s;
    logic signed [SUM_W-1:0] min_s;
    logic signed [SUM_W-1:0] max_s;
    logic                    moving;

    always_comb begin
        st_d    = st_q;
        step_s  = $signed({{(SUM_W-STEP_W){1'b0}}, step});
        fstep_s = $signed({{(SUM_W-STEP_W){1'b0}}, flt_step});
        min_s   = SUM_W'(clamp_min);
        max_s   = SUM_W'(clamp_max);
        sum     = SUM_W'(st_q.acc);
        moving  = 1'b0;
        case (adj)
            ADJ_UP: begin
                sum    = sum + step_s;
                moving = 1'b1;
            end
            ADJ_DOWN: begin
                sum    = sum - step_s;
                moving = 1'b1;
            end
            ADJ_FAULT: begin
                if (fault_go) begin
                    sum    = sum - fstep_s;
                    moving = 1'b1;
                end
            end
            default: moving = 1'b0;
        endcase
        if (sum > max_s) begin
            sum = max_s;
        end else if (sum < min_s) begin
            sum = min_s;
        end
        if (clear) begin
            st_d.acc = '0;
        end else if (upd && moving) begin
            st_d.acc = sum[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

    // R2, R3: leaving automatic operation empties the accumulator
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0));

    // R9: every applied update lands inside the bounds
    a_r9_within_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && upd && (clamp_min <= clamp_max))
        |=> (acc >= $past(clamp_min) || $stable(acc)) && (acc <= $past(clamp_max) || $stable(acc)));

    // R10: no strobe, no change
    a_r10_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !upd) |=> $stable(acc));

    // R6: an in-band measurement holds the accumulator
    a_r6_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && upd && adj == ADJ_HOLD) |=> $stable(acc));
endmodule

// File: rtl/sr_ontime_adjust.sv
module sr_ontime_adjust
    import sradj_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int OFS_W  = 12,
    parameter int STEP_W = 8,
    parameter int LIM_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    auto_mode,
    input  logic                    meas_valid,
    input  logic [CNT_W-1:0]        meas_cnt,
    input  logic signed [OFS_W-1:0] manual_ofs,
    input  logic [CNT_W-1:0]        target,
    input  logic [CNT_W-1:0]        hyst,
    input  logic [STEP_W-1:0]       step,
    input  logic [CNT_W-1:0]        flt_thresh,
    input  logic [STEP_W-1:0]       flt_step,
    input  logic [LIM_W-1:0]        flt_limit,
    input  logic signed [OFS_W-1:0] clamp_min,
    input  logic signed [OFS_W-1:0] clamp_max,
    output logic signed [OFS_W-1:0] ofs_out
);
    logic                    run_auto;
    logic                    clr;
    logic                    smp;
    adj_e                    cls;
    logic                    fault_go;
    logic signed [OFS_W-1:0] acc;

    assign run_auto = enable && auto_mode;
    assign clr      = !run_auto;
    assign smp      = run_auto && meas_valid;

    sradj_classify #(.CNT_W(CNT_W)) u_classify (
        .meas       (meas_cnt),
        .target     (target),
        .hyst       (hyst),
        .flt_thresh (flt_thresh),
        .cls        (cls)
    );

    sradj_fault_qual #(.LIM_W(LIM_W)) u_fault_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr),
        .sample   (smp),
        .is_fault (cls == ADJ_FAULT),
        .limit    (flt_limit),
        .qualify  (fault_go)
    );

    sradj_accum #(.OFS_W(OFS_W), .STEP_W(STEP_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr),
        .upd       (smp),
        .adj       (cls),
        .fault_go  (fault_go),
        .step      (step),
        .flt_step  (flt_step),
        .clamp_min (clamp_min),
        .clamp_max (clamp_max),
        .acc       (acc)
    );

    always_comb begin
        if (!enable) begin
            ofs_out = '0;
        end else if (!auto_mode) begin
            ofs_out = manual_ofs;
        end else begin
            ofs_out = acc;
        end
    end
endmodule

// File: tb/sr_ontime_adjust_tb_top.sv
module sr_ontime_adjust_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              auto_mode = 1'b0;
    logic              meas_valid = 1'b0;
    logic [6:0]        meas_cnt = '0;
    logic signed [11:0] manual_ofs = '0;
    logic [6:0]        target = 7'd40;
    logic [6:0]        hyst = 7'd4;
    logic [7:0]        step = 8'd2;
    logic [6:0]        flt_thresh = 7'd10;
    logic [7:0]        flt_step = 8'd20;
    logic [3:0]        flt_limit = 4'd3;
    logic signed [11:0] clamp_min = -12'sd200;
    logic signed [11:0] clamp_max = 12'sd100;
    logic signed [11:0] ofs_out;

    int num_chk  = 0;
    int num_fail = 0;

    always #5 clk = ~clk;

    sr_ontime_adjust dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .auto_mode(auto_mode),
        .meas_valid(meas_valid), .meas_cnt(meas_cnt), .manual_ofs(manual_ofs),
        .target(target), .hyst(hyst), .step(step), .flt_thresh(flt_thresh),
        .flt_step(flt_step), .flt_limit(flt_limit), .clamp_min(clamp_min),
        .clamp_max(clamp_max), .ofs_out(ofs_out)
    );

    task automatic check(input string req, input int exp);
        int act;
        act = int'(ofs_out);
        num_chk++;
        if (act != exp) begin
            num_fail++;
            $display("FAIL %s: ofs_out=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int m);
        @(negedge clk);
        meas_cnt   = 7'(m);
        meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 0);
    endtask

    task automatic t_manual;
        enable     = 1'b1;
        manual_ofs = -12'sd37;
        @(negedge clk);
        check("R3 manual pass", -37);
        strobe(100);
        check("R3 manual ignores strobe", -37);
    endtask

    task automatic t_auto_up;
        auto_mode = 1'b1;
        @(negedge clk);
        check("R3 auto starts at zero", 0);
        strobe(60);
        check("R4 lengthen", 2);
        strobe(60);
        check("R4 lengthen again", 4);
    endtask

    task automatic t_band;
        strobe(44);
        check("R6 upper edge holds", 4);
        strobe(36);
        check("R6 lower edge holds", 4);
    endtask

    task automatic t_down;
        strobe(35);
        check("R5 shorten", 2);
        strobe(10);
        check("R5 at threshold not fault", 0);
    endtask

    task automatic t_valid;
        @(negedge clk);
        meas_cnt = 7'd100;
        repeat (4) @(negedge clk);
        check("R10 no strobe no change", 0);
    endtask

    task automatic t_fault;
        strobe(5);
        check("R7 first fault holds", 0);
        strobe(5);
        check("R7 second fault holds", 0);
        strobe(5);
        check("R7 third fault reduces", -20);
        strobe(5);
        strobe(5);
        check("R7 run restarted", -20);
        strobe(5);
        check("R7 second qualified fault", -40);
    endtask

    task automatic t_fault_reset;
        strobe(5);
        strobe(5);
        strobe(40);
        check("R8 clean strobe", -40);
        strobe(5);
        strobe(5);
        check("R8 count was reset", -40);
        strobe(5);
        check("R8 full run after reset", -60);
    endtask

    task automatic t_clamp;
        step = 8'd50;
        strobe(60);
        check("R9 step up", -10);
        strobe(60);
        strobe(60);
        check("R9 before max", 90);
        strobe(60);
        check("R9 clamp max", 100);
        flt_step  = 8'd200;
        flt_limit = 4'd0;
        strobe(5);
        check("R7 limit zero acts as one", -100);
        strobe(5);
        check("R9 clamp min", -200);
        check("R11 signed negative", -200);
        step      = 8'd2;
        flt_step  = 8'd20;
        flt_limit = 4'd3;
    endtask

    task automatic t_disable;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R2 disabled output", 0);
        strobe(60);
        check("R2 strobe ignored", 0);
        enable = 1'b1;
        @(negedge clk);
        check("R2 cleared on re-enable", 0);
        strobe(60);
        check("R2 steps from zero", 2);
    endtask

    task automatic t_mode;
        strobe(60);
        check("R4 accumulate", 4);
        auto_mode  = 1'b0;
        manual_ofs = 12'sd55;
        @(negedge clk);
        check("R3 manual after auto", 55);
        strobe(5);
        check("R3 strobe ignored in manual", 55);
        auto_mode = 1'b1;
        @(negedge clk);
        check("R3 mode switch clears", 0);
        strobe(60);
        check("R3 steps from zero", 2);
    endtask

    initial begin
        t_reset();
        t_manual();
        t_auto_up();
        t_band();
        t_down();
        t_valid();
        t_fault();
        t_fault_reset();
        t_clamp();
        t_disable();
        t_mode();
        $display("%0d/%0d checks passed", num_chk - num_fail, num_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        num_chk++;
        num_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", num_chk - num_fail, num_chk);
        $finish;
    end
endmodule